// File: doc/BRIEF.md
# Wake Event Collector and Power-Management Signalling

This block sits between a network receiver and the host bus logic of a network adapter. The receive path reports three kinds of wake stimulus as single-cycle strobes: a magic packet match, a wake-up frame match, and a change of link state. The block decides whether each strobe counts as a wake event. It accepts a strobe only if the host has enabled power management and placed the function in a low-power state. The class of the strobe must also be allowed by its disable bit, and the board strap must not forbid wake-on-LAN.

An accepted event raises two sticky flags at once: a PME status flag in the power-management control/status register and a wake flag in the interrupt status register. While either flag is set, the block holds an active-low interrupt request low and an active-high LAN wake pin high. Software clears each flag by writing 1 to its bit. The disable bits live in a small option register. The board strap is captured while reset is held.

Top module: `wake_pme_ctrl`

## Requirements
- R1: After reset, both flags are 0, `pm_rdata` reads 0, `irq_n` is 1 and `lan_wake` is 0.
- R2: A write to the power-management register stores bit 8 as the enable and bits 1:0 as the power state. `pm_rdata` returns the flag at bit 15, the enable at bit 8 and the state at bits 1:0, with all other bits 0.
- R3: While the enable (bit 8) is 0, no strobe changes any output.
- R4: While the power state is 0 (D0), no strobe is accepted. States 1, 2 and 3 (D1, D2, D3) arm detection.
- R5: An accepted strobe of any class sets the PME flag (`pm_rdata[15]`, `pme_status`) and the wake flag (`sts_wake`) on the next clock edge.
- R6: `irq_n` is low and `lan_wake` is high exactly while at least one of the two flags is set.
- R7: Option bit 0 set to 1 suppresses magic-packet strobes and leaves wake-up frame strobes in effect.
- R8: Option bit 1 set to 1 suppresses link-change strobes and leaves magic-packet strobes in effect.
- R9: When `wol_off_strap` is 1 while reset is asserted, no strobe is accepted until the next reset, whatever the register contents.
- R10: Writing 1 to bit 15 of the power-management register clears only the PME flag. Writing 1 to bit 28 of the status register clears only the wake flag. Writing 0 to these bits leaves the flags unchanged.
- R11: An accepted strobe in the same cycle as a clearing write leaves the flag set.
- R12: Writing power state D0 disarms detection but leaves flags that are already set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wol_off_strap | input | 1 | Board strap that disables wake-on-LAN, captured during reset |
| magic_evt | input | 1 | Magic packet strobe |
| frame_evt | input | 1 | Wake-up frame strobe |
| link_evt | input | 1 | Link state change strobe |
| pm_wr | input | 1 | Write strobe for the power-management register |
| pm_wdata | input | 16 | Write data for the power-management register |
| pm_rdata | output | 16 | Read data of the power-management register |
| sts_wr | input | 1 | Write strobe for the interrupt status register |
| sts_wdata | input | 32 | Write data for the status register; bit 28 clears the wake flag |
| opt_wr | input | 1 | Write strobe for the option register |
| opt_wdata | input | 2 | Bit 0 disables magic-packet wake; bit 1 disables link-change wake |
| pme_status | output | 1 | PME flag |
| sts_wake | output | 1 | Wake flag of the status register |
| irq_n | output | 1 | Active-low interrupt request |
| lan_wake | output | 1 | Active-high LAN wake pin |

## Verification
The bench uses the default parameters. These place the PME flag at bit 15, the enable at bit 8 and the wake flag at bit 28, so the register encodings in the requirements are the ones being checked. With these values, every combination the requirements name is reached: both strap values across two resets, each power state, each disable bit, and strobes that coincide with clearing writes. Because the two flags are cleared separately, the bench also covers the case where one flag alone holds the pins active.

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl #(
  parameter int PM_W       = 16,
  parameter int STS_W      = 32,
  parameter int EN_BIT     = 8,
  parameter int PME_BIT    = 15,
  parameter int WAKE_BIT   = 28,
  parameter int PSTATE_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wol_off_strap,
  input  logic             magic_evt,
  input  logic             frame_evt,
  input  logic             link_evt,
  input  logic             pm_wr,
  input  logic [PM_W-1:0]  pm_wdata,
  output logic [PM_W-1:0]  pm_rdata,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             opt_wr,
  input  logic [1:0]       opt_wdata,
  output logic             pme_status,
  output logic             sts_wake,
  output logic             irq_n,
  output logic             lan_wake
);

  logic                hw_dis;
  logic                pm_en;
  logic [PSTATE_W-1:0] pstate;
  logic                magic_dis, link_dis;
  logic                pme_q, wake_q;
  logic                armed, hit, accept;
  logic                pme_clr, wake_clr;

  always_ff @(posedge clk)
    if (!rst_n) hw_dis <= wol_off_strap;

  assign armed  = !hw_dis && pm_en && (pstate != '0);
  assign hit    = (magic_evt && !magic_dis) || frame_evt || (link_evt && !link_dis);
  assign accept = armed && hit;

  assign pme_clr  = pm_wr  && pm_wdata[PME_BIT];
  assign wake_clr = sts_wr && sts_wdata[WAKE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_en     <= 1'b0;
      pstate    <= '0;
      magic_dis <= 1'b0;
      link_dis  <= 1'b0;
      pme_q     <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      if (pm_wr) begin
        pm_en  <= pm_wdata[EN_BIT];
        pstate <= pm_wdata[PSTATE_W-1:0];
      end
      if (opt_wr) begin
        magic_dis <= opt_wdata[0];
        link_dis  <= opt_wdata[1];
      end
      if (accept)       pme_q <= 1'b1;
      else if (pme_clr) pme_q <= 1'b0;
      if (accept)        wake_q <= 1'b1;
      else if (wake_clr) wake_q <= 1'b0;
    end
  end

  always_comb begin
    pm_rdata                   = '0;
    pm_rdata[PSTATE_W-1:0]     = pstate;
    pm_rdata[EN_BIT]           = pm_en;
    pm_rdata[PME_BIT]          = pme_q;
  end

  assign pme_status = pme_q;
  assign sts_wake   = wake_q;
  assign lan_wake   = pme_q || wake_q;
  assign irq_n      = !(pme_q || wake_q);

endmodule

module wake_pme_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hw_dis,
  input logic        pm_wr,
  input logic [15:0] pm_wdata,
  input logic [15:0] pm_rdata,
  input logic        pme_status,
  input logic        sts_wake,
  input logic        irq_n,
  input logic        lan_wake
);
  // R6
  pins_opposed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lan_wake != irq_n);
  // R5
  flags_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) |-> sts_wake);
  // R3
  needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_wake) |-> $past(pm_rdata[8]));
  // R4
  needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_wake) |-> ($past(pm_rdata[1:0]) != 2'd0));
  // R9
  strap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_status) |-> !$past(hw_dis));
  // R10
  pme_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_status) |-> $past(pm_wr && pm_wdata[15]));
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hw_dis(hw_dis), .pm_wr(pm_wr),
  .pm_wdata(pm_wdata), .pm_rdata(pm_rdata), .pme_status(pme_status),
  .sts_wake(sts_wake), .irq_n(irq_n), .lan_wake(lan_wake));

// File: tb/wake_pme_ctrl_tb.sv
module wake_pme_ctrl_tb_top;
  logic clk = 0, rst_n = 0, strap = 0;
  logic m = 0, f = 0, l = 0;
  logic pm_wr = 0, sts_wr = 0, opt_wr = 0;
  logic [15:0] pm_wdata = '0;
  logic [31:0] sts_wdata = '0;
  logic [1:0]  opt_wdata = '0;
  logic [15:0] pm_rdata;
  logic pme_status, sts_wake, irq_n, lan_wake;

  always #5 clk = ~clk;

  wake_pme_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wol_off_strap(strap),
    .magic_evt(m), .frame_evt(f), .link_evt(l),
    .pm_wr(pm_wr), .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .opt_wr(opt_wr), .opt_wdata(opt_wdata),
    .pme_status(pme_status), .sts_wake(sts_wake),
    .irq_n(irq_n), .lan_wake(lan_wake));

  typedef struct {
    logic [15:0] rd;
    logic        wk;
    logic        irqn;
    logic        lw;
    string       req;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_en, m_pme, m_wk, m_mdis, m_ldis, m_strap;
  logic [1:0] m_ps;

  task automatic push(string req);
    exp_t e;
    e.rd = '0; e.rd[15] = m_pme; e.rd[8] = m_en; e.rd[1:0] = m_ps;
    e.wk = m_wk; e.irqn = !(m_pme || m_wk); e.lw = m_pme || m_wk;
    e.req = req;
    q.push_back(e);
  endtask

  always begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pm_rdata !== e.rd || sts_wake !== e.wk || irq_n !== e.irqn ||
          lan_wake !== e.lw || pme_status !== e.rd[15]) begin
        fails++;
        $display("FAIL %s: got rd=%h wk=%b irq_n=%b lan=%b pme=%b exp rd=%h wk=%b irq_n=%b lan=%b",
                 e.req, pm_rdata, sts_wake, irq_n, lan_wake, pme_status,
                 e.rd, e.wk, e.irqn, e.lw);
      end
    end
  end

  task automatic do_reset(logic s, string req);
    @(negedge clk);
    strap = s; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_en = 0; m_pme = 0; m_wk = 0; m_mdis = 0; m_ldis = 0; m_ps = 0; m_strap = s;
    push(req);
  endtask

  task automatic cyc(logic pw, logic [15:0] pd, logic sw, logic [31:0] sd,
                     logic ow, logic [1:0] od, logic em, logic ef, logic el,
                     string req);
    logic acc;
    @(negedge clk);
    pm_wr = pw; pm_wdata = pd; sts_wr = sw; sts_wdata = sd;
    opt_wr = ow; opt_wdata = od; m = em; f = ef; l = el;
    acc = !m_strap && m_en && (m_ps != 0) &&
          ((em && !m_mdis) || ef || (el && !m_ldis));
    @(negedge clk);
    pm_wr = 0; sts_wr = 0; opt_wr = 0; m = 0; f = 0; l = 0;
    if (pw) begin m_en = pd[8]; m_ps = pd[1:0]; end
    if (ow) begin m_mdis = od[0]; m_ldis = od[1]; end
    if (acc) begin m_pme = 1; m_wk = 1; end
    else begin
      if (pw && pd[15]) m_pme = 0;
      if (sw && sd[28]) m_wk = 0;
    end
    push(req);
  endtask

  task automatic pmw(logic [15:0] d, string req);
    cyc(1, d, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic ev(logic em, logic ef, logic el, string req);
    cyc(0, 0, 0, 0, 0, 0, em, ef, el, req);
  endtask
  task automatic clr_all(string req);
    cyc(1, 16'h8000 | {m_pme, 6'b0, m_en, 6'b0, m_ps}, 1, 32'h1000_0000,
        0, 0, 0, 0, 0, req);
  endtask

  initial begin
    do_reset(0, "R1 reset state");
    pmw(16'h0101, "R2 write enable+D1");
    pmw(16'h0003, "R2 write D3 no enable");
    ev(1, 1, 1, "R3 events with enable off");
    pmw(16'h0100, "R4 enable in D0");
    ev(1, 1, 1, "R4 events in D0");
    pmw(16'h0102, "R4 arm D2");
    ev(0, 1, 0, "R5 R6 frame event sets flags");
    cyc(0, 0, 1, 32'h1000_0000, 0, 0, 0, 0, 0, "R10 clear wake only, pins held");
    pmw(16'h0102, "R10 write 0 to bit15 keeps pme");
    pmw(16'h8102, "R10 clear pme, pins released");
    cyc(0, 0, 0, 0, 1, 2'b01, 0, 0, 0, "R7 set magic disable");
    ev(1, 0, 0, "R7 magic suppressed");
    ev(0, 1, 0, "R7 frame still wakes");
    clr_all("R10 clear both");
    cyc(0, 0, 0, 0, 1, 2'b10, 0, 0, 0, "R8 set link disable");
    ev(0, 0, 1, "R8 link suppressed");
    ev(1, 0, 0, "R8 magic wakes");
    clr_all("R10 clear both again");
    cyc(0, 0, 0, 0, 1, 2'b00, 0, 0, 0, "R8 clear disables");
    ev(0, 0, 1, "R5 link event sets flags");
    cyc(1, 16'h8103, 1, 32'h1000_0000, 0, 0, 1, 0, 0, "R11 event beats clear");
    clr_all("R10 clear after collision");
    pmw(16'h0101, "R4 arm D1");
    ev(1, 0, 0, "R5 magic in D1");
    pmw(16'h0100, "R12 write D0 keeps flags");
    clr_all("R12 clear in D0");
    ev(1, 1, 1, "R12 D0 disarmed");
    do_reset(1, "R1 reset with strap");
    pmw(16'h0103, "R9 arm D3 with strap");
    ev(1, 1, 1, "R9 strap blocks all");
    do_reset(0, "R1 reset strap off");
    pmw(16'h0103, "R9 arm D3 strap off");
    ev(0, 1, 0, "R9 wake works after strap removed");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule